// File: doc/BRIEF.md
# Directed-Mode Mantissa Rounding Unit

This block is a combinational rounding stage for a sign-magnitude floating-point datapath. It receives a mantissa that carries two extra low-order bits, a separate sticky bit, the sign of the value and a 2-bit rounding-mode code. It drops the two extra bits and adds one at the new least significant bit when the selected mode calls for it. It returns the result, a flag for whether the increment was applied, and a flag for whether any discarded information was nonzero.

The result is one bit wider than the truncated mantissa. A carry that ripples out of an all-ones fraction therefore appears as a new leading bit. A later packing stage uses that bit and the rounded-up flag to renormalise and adjust the exponent. Exponent handling and format packing are not part of this block.

Top module: `mant_round_unit`

## Requirements
- R1: Bit 1 of `mant_i` is the guard bit and bit 0 is the round bit. The value before any increment is `mant_i >> 2`, zero-extended to FRAC_W+1 bits.
- R2: When guard, round and sticky are all 0, `mant_o` equals the truncated value and both `inexact_o` and `rounded_up_o` are 0, in every mode.
- R3: `inexact_o` is 1 exactly when at least one of guard, round or sticky is 1.
- R4: Mode 2'b00 (nearest, ties to even) increments only when guard is 1 and at least one of round, sticky or the truncated LSB is 1. A guard-only tie on an even value is left unchanged.
- R5: Mode 2'b01 (toward zero) never increments.
- R6: Mode 2'b10 (toward plus infinity) increments only when the result is inexact and `sign_i` is 0.
- R7: Mode 2'b11 (toward minus infinity) increments only when the result is inexact and `sign_i` is 1.
- R8: The increment carries through the whole mantissa. An all-ones truncated fraction that is incremented gives `mant_o` with bit FRAC_W set and all lower bits 0.
- R9: `rounded_up_o` is 1 exactly when `mant_o` equals the truncated value plus one, and 0 when it equals the truncated value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sign_i | input | 1 | Sign of the value, 1 = negative |
| mode_i | input | 2 | Rounding-mode code (see R4 to R7) |
| mant_i | input | FRAC_W+2 | Mantissa with guard and round bits at the bottom |
| sticky_i | input | 1 | OR of all bits shifted out below the round bit |
| mant_o | output | FRAC_W+1 | Rounded mantissa, with the carry-out bit at the top |
| rounded_up_o | output | 1 | The increment was applied |
| inexact_o | output | 1 | Discarded bits were nonzero |

## Verification
The hardest case to reach is a carry out of the full fraction. It needs an all-ones truncated value together with a mode, sign and guard/round/sticky combination that requests an increment. Random mantissas almost never produce that value. The bench therefore drives an all-ones fraction directly under every mode and every bit combination. The round-to-even tie is also reached on purpose: guard is 1, round and sticky are 0, and the bench drives both an even and an odd truncated value.

// File: rtl/mru_pkg.sv
// Shared types for the mantissa rounding unit.
// Assumes a 2-bit mode field; every code is decoded.
package mru_pkg;
    typedef enum logic [1:0] {
        RM_NEAREST = 2'b00,
        RM_ZERO    = 2'b01,
        RM_POS     = 2'b10,
        RM_NEG     = 2'b11
    } rmode_e;

    typedef struct packed {
        logic guard;
        logic rnd;
        logic sticky;
        logic lsb;
    } rbits_t;
endpackage

// File: rtl/mru_split.sv
// Splits the incoming mantissa into the truncated magnitude and the
// bits that drive the rounding decision.
// Assumes guard at bit 1 and round at bit 0 of the input.
module mru_split
    import mru_pkg::*;
#(
    parameter int FRAC_W = 24
) (
    input  logic [FRAC_W+1:0] mant_i,
    input  logic              sticky_i,
    output logic [FRAC_W-1:0] trunc_o,
    output rbits_t            bits_o
);
    // Drop the two extra bits and collect the decision inputs.
    always_comb begin
        trunc_o       = mant_i[FRAC_W+1:2];
        bits_o.guard  = mant_i[1];
        bits_o.rnd    = mant_i[0];
        bits_o.sticky = sticky_i;
        bits_o.lsb    = mant_i[2];
    end
endmodule

// File: rtl/mru_decide.sv
// Decides whether the truncated magnitude is bumped, from the mode,
// the sign and the discarded bits. Also flags inexact results.
// Assumes sign-magnitude values: directed modes act on the magnitude.
module mru_decide
    import mru_pkg::*;
(
    input  logic       sign_i,
    input  logic [1:0] mode_i,
    input  rbits_t     bits_i,
    output logic       bump_o,
    output logic       inexact_o
);
    rmode_e mode;
    logic   lost;

    // Decode the mode and merge the discarded bits.
    always_comb begin
        mode = rmode_e'(mode_i);
        lost = bits_i.guard | bits_i.rnd | bits_i.sticky;
    end

    // Per-mode increment decision.
    always_comb begin
        bump_o = 1'b0;
        if (lost) begin
            case (mode)
                RM_ZERO: bump_o = 1'b0;
                RM_POS:  bump_o = ~sign_i;
                RM_NEG:  bump_o = sign_i;
                default: bump_o = bits_i.guard &
                                  (bits_i.rnd | bits_i.sticky | bits_i.lsb);
            endcase
        end
    end

    // Inexact whenever anything was discarded.
    always_comb inexact_o = lost;

    // Checks beside the decision logic.
    always_comb begin
        a_r2_exact_no_bump: assert (inexact_o || !bump_o)
            else $error("bump on exact value");
        a_r5_rz_never_bumps: assert (mode_i != 2'b01 || !bump_o)
            else $error("toward-zero bumped");
        a_r6_pos_only_positive: assert (mode_i != 2'b10 || !bump_o || !sign_i)
            else $error("plus-inf bumped a negative value");
        a_r7_neg_only_negative: assert (mode_i != 2'b11 || !bump_o || sign_i)
            else $error("minus-inf bumped a positive value");
        a_r4_tie_even_kept: assert (mode_i != 2'b00 ||
                !(bits_i.guard && !bits_i.rnd && !bits_i.sticky && !bits_i.lsb) || !bump_o)
            else $error("even tie bumped");
    end
endmodule

// File: rtl/mru_incr.sv
// Adds the bump bit at the LSB of the truncated magnitude with a
// full ripple carry; the carry-out becomes the extra top bit.
// Assumes bump_i is 0 or 1 only.
module mru_incr #(
    parameter int FRAC_W = 24
) (
    input  logic [FRAC_W-1:0] trunc_i,
    input  logic              bump_i,
    output logic [FRAC_W:0]   sum_o
);
    logic [FRAC_W:0] carry;

    // Carry enters at the bottom.
    always_comb carry[0] = bump_i;

    genvar i;
    generate
        for (i = 0; i < FRAC_W; i++) begin : g_bit
            // One half-adder cell per bit.
            always_comb begin
                sum_o[i]   = trunc_i[i] ^ carry[i];
                carry[i+1] = trunc_i[i] & carry[i];
            end
        end
    endgenerate

    // The last carry is the new leading bit.
    always_comb sum_o[FRAC_W] = carry[FRAC_W];

    // Checks beside the carry chain.
    always_comb begin
        a_r8_carry_clears_low: assert (!sum_o[FRAC_W] || (sum_o[FRAC_W-1:0] == '0 && &trunc_i))
            else $error("carry-out with nonzero fraction");
        a_r8_sum_value: assert (sum_o == ({1'b0, trunc_i} + {{FRAC_W{1'b0}}, bump_i}))
            else $error("ripple sum wrong");
    end
endmodule

// File: rtl/mant_round_unit.sv
// Top of the mantissa rounding unit. Combinational: split, decide,
// increment. Output is one bit wider so a carry-out is visible.
// Assumes the caller renormalises and adjusts the exponent.
module mant_round_unit
    import mru_pkg::*;
#(
    parameter int FRAC_W = 24
) (
    input  logic              sign_i,
    input  logic [1:0]        mode_i,
    input  logic [FRAC_W+1:0] mant_i,
    input  logic              sticky_i,
    output logic [FRAC_W:0]   mant_o,
    output logic              rounded_up_o,
    output logic              inexact_o
);
    localparam int OUT_W = FRAC_W + 1;

    logic [FRAC_W-1:0] trunc;
    rbits_t            bits;
    logic              bump;

    mru_split #(.FRAC_W(FRAC_W)) u_split (
        .mant_i   (mant_i),
        .sticky_i (sticky_i),
        .trunc_o  (trunc),
        .bits_o   (bits)
    );

    mru_decide u_decide (
        .sign_i    (sign_i),
        .mode_i    (mode_i),
        .bits_i    (bits),
        .bump_o    (bump),
        .inexact_o (inexact_o)
    );

    mru_incr #(.FRAC_W(FRAC_W)) u_incr (
        .trunc_i (trunc),
        .bump_i  (bump),
        .sum_o   (mant_o)
    );

    // Report the decision taken.
    always_comb rounded_up_o = bump;

    // Output-level checks against the raw input port.
    always_comb begin
        a_r9_flag_matches_value: assert (rounded_up_o ==
                (mant_o != OUT_W'(mant_i >> 2)))
            else $error("rounded-up flag disagrees with result");
        a_r3_inexact_flag: assert (inexact_o == ((mant_i[1:0] != 2'b00) || sticky_i))
            else $error("inexact flag wrong");
    end
endmodule

// File: tb/sim_mant_round_unit.sv
module sim_mant_round_unit;
    localparam int FW = 24;

    logic          clk = 1'b0;
    logic          sign_i = 1'b0;
    logic [1:0]    mode_i = 2'b00;
    logic [FW+1:0] mant_i = '0;
    logic          sticky_i = 1'b0;
    logic [FW:0]   mant_o;
    logic          rounded_up_o;
    logic          inexact_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    mant_round_unit #(.FRAC_W(FW)) u0 (
        .sign_i(sign_i), .mode_i(mode_i), .mant_i(mant_i), .sticky_i(sticky_i),
        .mant_o(mant_o), .rounded_up_o(rounded_up_o), .inexact_o(inexact_o)
    );

    function automatic string mode_tag(logic [1:0] m);
        case (m)
            2'b01: return "R5";
            2'b10: return "R6";
            2'b11: return "R7";
            default: return "R4";
        endcase
    endfunction

    // Reference decision from the requirements.
    function automatic bit ref_up(logic s, logic [1:0] m, logic g, logic r, logic st, logic l);
        bit any = g | r | st;
        if (!any) return 0;
        case (m)
            2'b00: return g & (r | st | l);
            2'b01: return 0;
            2'b10: return !s;
            default: return s;
        endcase
    endfunction

    task automatic apply(logic s, logic [1:0] m, logic [FW+1:0] v, logic st);
        @(negedge clk);
        sign_i = s; mode_i = m; mant_i = v; sticky_i = st;
        #1;
    endtask

    task automatic chk(string tag, logic [FW:0] act, logic [FW:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h (mode=%0d sign=%0d mant=%h st=%0d)",
                     tag, act, exp, mode_i, sign_i, mant_i, sticky_i);
        end
    endtask

    task automatic check_one(logic s, logic [1:0] m, logic [FW+1:0] v, logic st);
        logic [FW:0] tr;
        bit up;
        apply(s, m, v, st);
        tr = {1'b0, v[FW+1:2]};
        up = ref_up(s, m, v[1], v[0], st, v[2]);
        chk(mode_tag(m), mant_o, tr + (FW+1)'(up));
        chk("R9", {{FW{1'b0}}, rounded_up_o}, {{FW{1'b0}}, up});
        chk("R3", {{FW{1'b0}}, inexact_o}, {{FW{1'b0}}, (v[1] | v[0] | st)});
    endtask

    // Idle inputs: zero in, zero out.
    task automatic t_reset_state();
        apply(0, 2'b00, '0, 0);
        chk("R2", mant_o, '0);
        chk("R2", {{FW{1'b0}}, rounded_up_o, inexact_o}, '0);
    endtask

    // Every mode, guard/round/sticky combination, sign and LSB parity.
    task automatic t_exhaustive();
        logic [FW-1:0] bases [2] = '{24'h5A3C10, 24'h0F0F00};
        for (int b = 0; b < 2; b++)
            for (int m = 0; m < 4; m++)
                for (int grs = 0; grs < 8; grs++)
                    for (int s = 0; s < 2; s++)
                        for (int l = 0; l < 2; l++) begin
                            logic [FW-1:0] t = bases[b] | FW'(l);
                            check_one(s[0], m[1:0], {t, grs[2:1]}, grs[0]);
                        end
    endtask

    // R1/R2: exact values pass truncated in every mode.
    task automatic t_exact();
        for (int m = 0; m < 4; m++) begin
            apply(1, m[1:0], {24'hABCDEF, 2'b00}, 0);
            chk("R1", mant_o, {1'b0, 24'hABCDEF});
            chk("R2", {{FW-1{1'b0}}, rounded_up_o, inexact_o}, '0);
        end
    endtask

    // R4: ties on even and odd values.
    task automatic t_ties();
        apply(0, 2'b00, {24'h000010, 2'b10}, 0);
        chk("R4", mant_o, {1'b0, 24'h000010});
        apply(0, 2'b00, {24'h000011, 2'b10}, 0);
        chk("R4", mant_o, {1'b0, 24'h000012});
    endtask

    // R8: all-ones fraction carries out.
    task automatic t_carry();
        for (int m = 0; m < 4; m++)
            for (int grs = 0; grs < 8; grs++)
                for (int s = 0; s < 2; s++) begin
                    bit up = ref_up(s[0], m[1:0], grs[2], grs[1], grs[0], 1'b1);
                    apply(s[0], m[1:0], {{FW{1'b1}}, grs[2:1]}, grs[0]);
                    chk("R8", mant_o, up ? {1'b1, {FW{1'b0}}} : {1'b0, {FW{1'b1}}});
                end
    endtask

    initial begin
        t_reset_state();
        t_exact();
        t_ties();
        t_exhaustive();
        t_carry();
        done = 1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired actual=running expected=done");
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule